// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier with Supply Lockout

This block sits between the active-low control pins of a flash device and its command register. It decides which write-enable strobes count as genuine write cycles. Each of the three control pins, chip enable, output enable and write enable, is brought into the clock domain and passed through a persistence filter. The supply-lockout flag is also synchronised. A write is handed to the command logic as a single-cycle `wrStrobe`. It is issued when the filtered write enable rises, provided two things hold: the write condition stayed true for the whole low phase of write enable, and the block is armed.

The block also drives a single-cycle `forceRead` pulse, which returns the command logic to read mode. The pulse fires once after reset is released and again each time the lockout flag is raised. While lockout is active, no write is accepted. After reset or after lockout, write enable must first be seen high through its filter before a later rising edge can count. As a result, a device that powers up with write enable already low never turns its first rising edge into a command.

Top module: `flash_write_qualifier`

## Requirements
- R1: After reset is released, `forceRead` pulses high exactly once, and `wrStrobe` stays low during and after reset while no write is driven.
- R2: With `ceN` low and `oeN` high, a low then high pulse on `weN` produces exactly one `wrStrobe` pulse, within a bounded number of cycles after the rise. Every pin phase must last at least GLITCH_CYCLES clocks.
- R3: A write-enable pulse given while `oeN` is low produces no `wrStrobe`.
- R4: A write-enable pulse given while `ceN` is high produces no `wrStrobe`.
- R5: With `ceN` low and `oeN` high, no `wrStrobe` is produced as long as `weN` stays high.
- R6: Any pulse on `ceN`, `oeN` or `weN` that lasts fewer than GLITCH_CYCLES clocks is ignored. A short low pulse on `weN` starts no write. A short inverting pulse on `ceN` or `oeN` during a write does not cancel that write.
- R7: If `ceN` is high for GLITCH_CYCLES clocks or more at any point while `weN` is low, the following rise of `weN` produces no `wrStrobe`.
- R8: Each rise of `supplyLow` produces one `forceRead` pulse. No `wrStrobe` is produced while `supplyLow` is held high.
- R9: If `weN` is held low across the release of `supplyLow`, its next rise is rejected. A complete write after that is accepted.
- R10: If reset is released while `ceN` is low, `oeN` is high and `weN` is low, the first rise of `weN` is rejected. A later complete write is accepted.
- R11: `wrStrobe` and `forceRead` each stay high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low reset, treated as power-up |
| ceN | input | 1 | Chip enable pin, active low, asynchronous |
| oeN | input | 1 | Output enable pin, active low, asynchronous |
| weN | input | 1 | Write enable pin, active low, asynchronous |
| supplyLow | input | 1 | Supply-lockout flag, high while supply is under threshold |
| wrStrobe | output | 1 | One-cycle pulse for each accepted write cycle |
| forceRead | output | 1 | One-cycle pulse that returns command logic to read mode |

## Verification
The assertions rely on two assumptions about the pins. The first is that the pins reach the clock domain only through the synchronisers. The second is that GLITCH_CYCLES is at least two, so that a filtered level change always rests on at least two matching samples. The stimulus drives every pin change on the falling clock edge and holds every intended level for longer than the filter and synchroniser latency combined. It then waits out that latency before sampling pulse counts. Deliberate glitches are kept exactly one sample short of the threshold, so each glitch is well defined.

// File: rtl/fwq_pkg.sv
package fwq_pkg;

  // Filtered, clock-domain view of the pins handed from datapath to control
  typedef struct packed {
    logic ceLow;
    logic oeLow;
    logic weLow;
    logic weRise;
    logic lockOn;
  } pinView_t;

  localparam int NUM_PINS = 3;
  localparam int PIN_CE = 0;
  localparam int PIN_OE = 1;
  localparam int PIN_WE = 2;

endpackage

// File: rtl/fwq_glitch_filter.sv
module fwq_glitch_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 4,
  parameter bit RESET_LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  output logic pinClean
);

  localparam int CW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic sampled;
  logic [CW-1:0] runLen;
  logic level;

  // Synchroniser chain; SYNC_STAGES is expected to be 2 or more
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= {SYNC_STAGES{RESET_LEVEL}};
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinRaw};
  end

  assign sampled = syncQ[SYNC_STAGES-1];

  // Persistence counter: a new level must be seen GLITCH_CYCLES samples in a row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= RESET_LEVEL;
      runLen <= '0;
    end else if (sampled == level) begin
      runLen <= '0;
    end else if (runLen == LAST) begin
      level  <= sampled;
      runLen <= '0;
    end else begin
      runLen <= runLen + 1'b1;
    end
  end

  assign pinClean = level;

  generate
    if (GLITCH_CYCLES >= 2) begin : g_chk
      // R6
      filt_persist_chk: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(level) |-> ($past(sampled, 1) == $past(sampled, 2)));
    end
  endgenerate

endmodule

// File: rtl/fwq_pin_datapath.sv
module fwq_pin_datapath
  import fwq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     oeN,
  input  logic     weN,
  input  logic     supplyLow,
  output pinView_t pv
);

  // Write enable resets to "low" so that it must be proven high after power-up
  localparam logic [NUM_PINS-1:0] PIN_RESET = 3'b011;

  logic [NUM_PINS-1:0] rawPins;
  logic [NUM_PINS-1:0] cleanPins;
  logic [SYNC_STAGES-1:0] lockQ;
  logic weHighD;

  assign rawPins[PIN_CE] = ceN;
  assign rawPins[PIN_OE] = oeN;
  assign rawPins[PIN_WE] = weN;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      fwq_glitch_filter #(
        .SYNC_STAGES  (SYNC_STAGES),
        .GLITCH_CYCLES(GLITCH_CYCLES),
        .RESET_LEVEL  (PIN_RESET[i])
      ) u_filt (
        .clk     (clk),
        .rstN    (rstN),
        .pinRaw  (rawPins[i]),
        .pinClean(cleanPins[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ   <= '0;
      weHighD <= 1'b0;
    end else begin
      lockQ   <= {lockQ[SYNC_STAGES-2:0], supplyLow};
      weHighD <= cleanPins[PIN_WE];
    end
  end

  always_comb begin
    pv.ceLow  = ~cleanPins[PIN_CE];
    pv.oeLow  = ~cleanPins[PIN_OE];
    pv.weLow  = ~cleanPins[PIN_WE];
    pv.weRise = cleanPins[PIN_WE] & ~weHighD;
    pv.lockOn = lockQ[SYNC_STAGES-1];
  end

  // R2
  we_rise_from_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    pv.weRise |-> $past(pv.weLow));

endmodule

// File: rtl/fwq_write_control.sv
module fwq_write_control
  import fwq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  pinView_t pv,
  output logic     wrStrobe,
  output logic     forceRead
);

  logic porPending;
  logic lockD;
  logic armed;
  logic condHeld;
  logic wrQ;
  logic frQ;
  logic lockRise;
  logic condNow;
  logic acceptWr;

  assign lockRise = pv.lockOn & ~lockD;
  assign condNow  = pv.ceLow & ~pv.oeLow;
  assign acceptWr = pv.weRise & armed & condHeld & condNow & ~pv.lockOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porPending <= 1'b1;
      lockD      <= 1'b0;
      armed      <= 1'b0;
      condHeld   <= 1'b0;
      wrQ        <= 1'b0;
      frQ        <= 1'b0;
    end else begin
      porPending <= 1'b0;
      lockD      <= pv.lockOn;
      frQ        <= porPending | lockRise;
      wrQ        <= acceptWr;
      // Arming: lockout disarms, a filtered high write enable re-arms
      if (pv.lockOn)      armed <= 1'b0;
      else if (!pv.weLow) armed <= 1'b1;
      // Condition must hold for the whole low phase of write enable
      if (!pv.weLow) condHeld <= condNow;
      else           condHeld <= condHeld & condNow;
    end
  end

  assign wrStrobe  = wrQ;
  assign forceRead = frQ;

  // R11
  wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R8
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pv.lockOn && $past(pv.lockOn)) |-> !wrStrobe);

  // R3
  wr_pins_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $past(pv.ceLow && !pv.oeLow && pv.weRise));

  // R8
  lock_forces_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pv.lockOn) |=> forceRead);

endmodule

// File: rtl/flash_write_qualifier.sv
module flash_write_qualifier
  import fwq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  input  logic supplyLow,
  output logic wrStrobe,
  output logic forceRead
);

  pinView_t pinView;

  fwq_pin_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .GLITCH_CYCLES(GLITCH_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .weN      (weN),
    .supplyLow(supplyLow),
    .pv       (pinView)
  );

  fwq_write_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .pv       (pinView),
    .wrStrobe (wrStrobe),
    .forceRead(forceRead)
  );

endmodule

// File: tb/flash_write_qualifier_tb.sv
`timescale 1ns/100ps
module flash_write_qualifier_tb;

  localparam int SYNC   = 2;
  localparam int GLITCH = 4;
  localparam int SETTLE = SYNC + GLITCH + 6;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, supplyLow = 1'b0;
  logic wrStrobe, forceRead;

  int checks = 0;
  int fails = 0;
  int wrCount = 0, frCount = 0;
  int wrWide = 0, frWide = 0;
  logic prevWr = 1'b0, prevFr = 1'b0;

  always #2.5 clk = ~clk;

  flash_write_qualifier #(.SYNC_STAGES(SYNC), .GLITCH_CYCLES(GLITCH)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .supplyLow(supplyLow), .wrStrobe(wrStrobe), .forceRead(forceRead));

  // Pulse monitor sampling away from the active edge
  always @(negedge clk) begin
    if (wrStrobe) wrCount++;
    if (forceRead) frCount++;
    if (wrStrobe && prevWr) wrWide++;
    if (forceRead && prevFr) frWide++;
    prevWr = wrStrobe;
    prevFr = forceRead;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic full_write(input int ph);
    ceN = 1'b0; oeN = 1'b1; hold(ph);
    weN = 1'b0; hold(ph);
    weN = 1'b1; hold(ph);
    ceN = 1'b1; hold(ph);
  endtask

  task automatic t_reset();
    int f0;
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; supplyLow = 1'b0;
    hold(4);
    check(wrStrobe == 1'b0, "R1 wrStrobe in reset", wrStrobe, 0);
    check(forceRead == 1'b0, "R1 forceRead in reset", forceRead, 0);
    f0 = frCount;
    wrCount = 0;
    rstN = 1'b1; hold(SETTLE * 2);
    check(frCount - f0 == 1, "R1 forceRead after reset", frCount - f0, 1);
    check(wrCount == 0, "R1 no write after reset", wrCount, 0);
  endtask

  task automatic t_legal();
    int w0 = wrCount;
    full_write(SETTLE);
    check(wrCount - w0 == 1, "R2 legal write slow", wrCount - w0, 1);
    w0 = wrCount;
    full_write(GLITCH);
    hold(SETTLE);
    check(wrCount - w0 == 1, "R2 legal write minimum phases", wrCount - w0, 1);
    w0 = wrCount;
    full_write(SETTLE); full_write(GLITCH + 1); hold(SETTLE);
    check(wrCount - w0 == 2, "R2 back-to-back writes", wrCount - w0, 2);
  endtask

  task automatic t_inhibit();
    int w0 = wrCount;
    ceN = 1'b0; oeN = 1'b0; hold(SETTLE);
    weN = 1'b0; hold(SETTLE); weN = 1'b1; hold(SETTLE);
    ceN = 1'b1; oeN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R3 oe low inhibits", wrCount - w0, 0);
    w0 = wrCount;
    ceN = 1'b1; oeN = 1'b1; hold(SETTLE);
    weN = 1'b0; hold(SETTLE); weN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R4 ce high inhibits", wrCount - w0, 0);
    w0 = wrCount;
    ceN = 1'b0; oeN = 1'b1; hold(SETTLE * 4); ceN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R5 we high inhibits", wrCount - w0, 0);
  endtask

  task automatic t_glitch();
    int w0 = wrCount;
    ceN = 1'b0; oeN = 1'b1; hold(SETTLE);
    weN = 1'b0; hold(GLITCH - 1); weN = 1'b1; hold(SETTLE);
    ceN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R6 short we pulse ignored", wrCount - w0, 0);
    w0 = wrCount;
    ceN = 1'b0; hold(SETTLE); weN = 1'b0; hold(SETTLE);
    ceN = 1'b1; hold(GLITCH - 1); ceN = 1'b0; hold(SETTLE);
    weN = 1'b1; hold(SETTLE); ceN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 1, "R6 short ce glitch ignored", wrCount - w0, 1);
    w0 = wrCount;
    ceN = 1'b0; hold(SETTLE); weN = 1'b0; hold(SETTLE);
    oeN = 1'b0; hold(GLITCH - 1); oeN = 1'b1; hold(SETTLE);
    weN = 1'b1; hold(SETTLE); ceN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 1, "R6 short oe glitch ignored", wrCount - w0, 1);
  endtask

  task automatic t_ce_break();
    int w0 = wrCount;
    ceN = 1'b0; oeN = 1'b1; hold(SETTLE); weN = 1'b0; hold(SETTLE);
    ceN = 1'b1; hold(SETTLE); ceN = 1'b0; hold(SETTLE);
    weN = 1'b1; hold(SETTLE); ceN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R7 ce break during we low", wrCount - w0, 0);
  endtask

  task automatic t_lockout();
    int w0 = wrCount;
    int f0 = frCount;
    ceN = 1'b0; oeN = 1'b1; hold(SETTLE); weN = 1'b0; hold(SETTLE);
    supplyLow = 1'b1; hold(SETTLE);
    check(frCount - f0 == 1, "R8 forceRead on lockout", frCount - f0, 1);
    weN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R8 no write in lockout", wrCount - w0, 0);
    full_write(SETTLE);
    check(wrCount - w0 == 0, "R8 full write in lockout ignored", wrCount - w0, 0);
    ceN = 1'b0; hold(SETTLE); weN = 1'b0; hold(SETTLE);
    supplyLow = 1'b0; hold(SETTLE);
    weN = 1'b1; hold(SETTLE); ceN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R9 first rise after release rejected", wrCount - w0, 0);
    full_write(SETTLE);
    check(wrCount - w0 == 1, "R9 write after re-arm", wrCount - w0, 1);
    check(frCount - f0 == 1, "R8 single forceRead per lockout", frCount - f0, 1);
  endtask

  task automatic t_powerup();
    int w0, f0;
    rstN = 1'b0; ceN = 1'b0; oeN = 1'b1; weN = 1'b0; supplyLow = 1'b0;
    hold(4);
    w0 = wrCount; f0 = frCount;
    rstN = 1'b1; hold(SETTLE * 2);
    check(frCount - f0 == 1, "R10 forceRead at power-up", frCount - f0, 1);
    weN = 1'b1; hold(SETTLE); ceN = 1'b1; hold(SETTLE);
    check(wrCount - w0 == 0, "R10 first rise rejected", wrCount - w0, 0);
    full_write(SETTLE);
    check(wrCount - w0 == 1, "R10 later write accepted", wrCount - w0, 1);
  endtask

  task automatic run_all();
    t_reset();
    t_legal();
    t_inhibit();
    t_glitch();
    t_ce_break();
    t_lockout();
    t_powerup();
    check(wrWide == 0, "R11 wrStrobe width", wrWide, 0);
    check(frWide == 0, "R11 forceRead width", frWide, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule